// File: doc/BRIEF.md
# Indirect Branch Landing Pad Checker

This block sits beside the retire stage of a processor pipeline and enforces landing-pad discipline on indirect jumps and calls. Each retired instruction word is decoded for two shapes only: a jump-register (JALR) and a landing pad. A landing pad is an AUIPC whose destination is x0, and it carries a 20-bit label in its upper immediate. When a jump-register that is not exempt retires, the checker arms a one-bit expectation. The next retired instruction must then be a landing pad on a 4-byte boundary, and its label must be zero or equal to bits [31:12] of x7. Otherwise the checker raises a software-check exception.

Jumps through x1 or x5 count as returns, which another mechanism protects, so they never arm the checker. Jumps through x7 also never arm it, because they are treated as software-guarded jumps. A per-task enable bit switches the whole check off.

The control is a two-state machine, IDLE and ARMED. It has four named transitions:
- T_ARM: IDLE to ARMED, when a tracked jump retires while enabled.
- T_HOLD: stay in ARMED on a cycle with no retire.
- T_RESOLVE: ARMED to IDLE on the next retire, whether that instruction passes or faults.
- T_DISARM: any state to IDLE while the enable is low.

In every other case the state stays where it is.

Top module: `lpad_guard`

## Requirements
- R1: After a synchronous active-high reset, `exc_vld`, `exc_cause` and `exc_tval` are zero and the checker is IDLE, so a non-pad instruction retired next raises nothing.
- R2: A retired JALR (bits [6:0]=1100111, funct3 bits [14:12]=000) whose rs1 (bits [19:15]) is neither x1, x5 nor x7 arms the checker while enabled; if the next retired instruction is not a landing pad, an exception is raised.
- R3: A JALR through rs1 = x1 or rs1 = x5 does not arm the checker; a non-pad instruction retired after it raises nothing.
- R4: A JALR through rs1 = x7 does not arm the checker; a non-pad instruction retired after it raises nothing.
- R5: A landing pad (bits [6:0]=0010111, rd bits [11:7]=0) with label bits [31:12] equal to zero satisfies an armed checker, whatever x7 holds.
- R6: A landing pad with a nonzero label satisfies an armed checker only if the label equals x7[31:12]; the other bits of x7 are ignored; a mismatch raises an exception.
- R7: A landing pad retired while armed with PC bits [1:0] not zero raises an exception.
- R8: The armed state survives cycles without a retire and clears after exactly one retired instruction, whether that instruction passed or faulted.
- R9: While the enable is low no exception is raised and the checker returns to IDLE, so an armed state is lost.
- R10: An exception shows as `exc_vld` high for exactly one cycle, starting on the clock edge that samples the offending retire, with `exc_cause` = 18 and `exc_tval` = 2; both are zero whenever `exc_vld` is low.
- R11: While IDLE, no retired instruction raises an exception, including a misaligned pad or a pad whose label does not match x7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Per-task enable for landing-pad tracking |
| retire_vld | input | 1 | One instruction retires this cycle |
| retire_insn | input | 32 | Retiring instruction word |
| retire_pc | input | XLEN | PC of the retiring instruction |
| x7_val | input | XLEN | Current value of register x7 |
| exc_vld | output | 1 | Software-check exception pulse |
| exc_cause | output | CAUSE_W | Exception cause (18 when raised) |
| exc_tval | output | XLEN | Trap value (2 when raised) |

## Verification
The one-bit expectation is the only internal state, and it can be observed only through what the next retire does. If the state wrongly stays IDLE, a missing pad or a bad label passes silently. If the state is wrongly ARMED, an ordinary instruction raises a spurious exception. Either error shows on `exc_vld` one edge after the second retire. The directed scenarios therefore always follow an arming event, or a non-arming one, with a probe instruction whose expected outcome separates the two states. Those events include exempt jumps, idle gaps, disabled cycles and a faulting retire.

// File: rtl/lpad_guard_pkg.sv
package lpad_guard_pkg;

    localparam int ILEN       = 32;
    localparam int LBL_LSB    = 12;
    localparam int LBL_W      = ILEN - LBL_LSB;
    localparam int LBL_MSB    = LBL_LSB + LBL_W - 1;
    localparam int REG_W      = 5;

    localparam logic [6:0] OPC_JALR  = 7'b1100111;
    localparam logic [6:0] OPC_AUIPC = 7'b0010111;
    localparam logic [2:0] F3_JALR   = 3'b000;

    localparam int N_EXEMPT = 3;
    localparam logic [REG_W-1:0] EXEMPT_REGS [N_EXEMPT] = '{5'd1, 5'd5, 5'd7};

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } lp_state_e;

    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_NO_PAD   = 2'd1,
        FLT_MISALIGN = 2'd2,
        FLT_LABEL    = 2'd3
    } lp_fault_e;

endpackage

// File: rtl/lpad_guard_decode.sv
module lpad_guard_decode
    import lpad_guard_pkg::*;
(
    input  logic [ILEN-1:0]  insn,
    output logic             is_jalr,
    output logic             jalr_exempt,
    output logic             is_pad,
    output logic [LBL_W-1:0] pad_label
);

    logic [6:0]       opcode;
    logic [REG_W-1:0] rd;
    logic [2:0]       funct3;
    logic [REG_W-1:0] rs1;
    logic [N_EXEMPT-1:0] exempt_hit;

    assign opcode = insn[6:0];
    assign rd     = insn[11:7];
    assign funct3 = insn[14:12];
    assign rs1    = insn[19:15];

    genvar gi;
    generate
        for (gi = 0; gi < N_EXEMPT; gi++) begin : g_exempt
            assign exempt_hit[gi] = (rs1 == EXEMPT_REGS[gi]);
        end
    endgenerate

    assign is_jalr     = (opcode == OPC_JALR) && (funct3 == F3_JALR);
    assign jalr_exempt = |exempt_hit;
    assign is_pad      = (opcode == OPC_AUIPC) && (rd == '0);
    assign pad_label   = insn[LBL_MSB:LBL_LSB];

endmodule

// File: rtl/lpad_guard_pad_check.sv
module lpad_guard_pad_check
    import lpad_guard_pkg::*;
#(
    parameter int ALIGN_BITS = 2
) (
    input  logic                  is_pad,
    input  logic [LBL_W-1:0]      pad_label,
    input  logic [ALIGN_BITS-1:0] pc_low,
    input  logic [LBL_W-1:0]      x7_label,
    output lp_fault_e             fault
);

    logic misaligned;
    logic label_bad;

    assign misaligned = (pc_low != '0);
    assign label_bad  = (pad_label != '0) && (pad_label != x7_label);

    always_comb begin
        if (!is_pad) begin
            fault = FLT_NO_PAD;
        end else if (misaligned) begin
            fault = FLT_MISALIGN;
        end else if (label_bad) begin
            fault = FLT_LABEL;
        end else begin
            fault = FLT_NONE;
        end
    end

endmodule

// File: rtl/lpad_guard_fsm.sv
module lpad_guard_fsm
    import lpad_guard_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter int CAUSE_W     = 8,
    parameter int CAUSE_SWCHK = 18,
    parameter int TVAL_LPAD   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               retire_vld,
    input  logic               is_jalr,
    input  logic               jalr_exempt,
    input  lp_fault_e          fault,
    output logic               armed,
    output logic               exc_vld,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic [XLEN-1:0]    exc_tval
);

    lp_state_e state_q;
    lp_state_e state_d;
    logic      raise;

    // next-state logic: T_DISARM, T_ARM, T_HOLD, T_RESOLVE
    always_comb begin
        state_d = state_q;
        raise   = 1'b0;
        if (!en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (retire_vld && is_jalr && !jalr_exempt) begin
                        state_d = ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (retire_vld) begin
                        state_d = ST_IDLE;
                        raise   = (fault != FLT_NONE);
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            exc_vld   <= 1'b0;
            exc_cause <= '0;
            exc_tval  <= '0;
        end else if (raise) begin
            exc_vld   <= 1'b1;
            exc_cause <= CAUSE_W'(CAUSE_SWCHK);
            exc_tval  <= XLEN'(TVAL_LPAD);
        end else begin
            exc_vld   <= 1'b0;
            exc_cause <= '0;
            exc_tval  <= '0;
        end
    end

    assign armed = (state_q == ST_ARMED);

endmodule

// File: rtl/lpad_guard.sv
module lpad_guard
    import lpad_guard_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter int CAUSE_W     = 8,
    parameter int ALIGN_BITS  = 2,
    parameter int CAUSE_SWCHK = 18,
    parameter int TVAL_LPAD   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               retire_vld,
    input  logic [ILEN-1:0]    retire_insn,
    input  logic [XLEN-1:0]    retire_pc,
    input  logic [XLEN-1:0]    x7_val,
    output logic               exc_vld,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic [XLEN-1:0]    exc_tval
);

    logic             is_jalr;
    logic             jalr_exempt;
    logic             is_pad;
    logic [LBL_W-1:0] pad_label;
    lp_fault_e        fault;
    logic             armed;
    logic             unused_bits;

    assign unused_bits = ^{retire_pc[XLEN-1:ALIGN_BITS], x7_val[XLEN-1:LBL_MSB+1],
                           x7_val[LBL_LSB-1:0]};

    lpad_guard_decode u_decode (
        .insn        (retire_insn),
        .is_jalr     (is_jalr),
        .jalr_exempt (jalr_exempt),
        .is_pad      (is_pad),
        .pad_label   (pad_label)
    );

    lpad_guard_pad_check #(
        .ALIGN_BITS (ALIGN_BITS)
    ) u_pad_check (
        .is_pad    (is_pad),
        .pad_label (pad_label),
        .pc_low    (retire_pc[ALIGN_BITS-1:0]),
        .x7_label  (x7_val[LBL_MSB:LBL_LSB]),
        .fault     (fault)
    );

    lpad_guard_fsm #(
        .XLEN        (XLEN),
        .CAUSE_W     (CAUSE_W),
        .CAUSE_SWCHK (CAUSE_SWCHK),
        .TVAL_LPAD   (TVAL_LPAD)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .retire_vld  (retire_vld),
        .is_jalr     (is_jalr),
        .jalr_exempt (jalr_exempt),
        .fault       (fault),
        .armed       (armed),
        .exc_vld     (exc_vld),
        .exc_cause   (exc_cause),
        .exc_tval    (exc_tval)
    );

endmodule

// File: rtl/lpad_guard_sva.sv
module lpad_guard_sva #(
    parameter int XLEN        = 64,
    parameter int CAUSE_W     = 8,
    parameter int CAUSE_SWCHK = 18,
    parameter int TVAL_LPAD   = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               en,
    input logic               retire_vld,
    input logic [31:0]        retire_insn,
    input logic               armed,
    input logic               exc_vld,
    input logic [CAUSE_W-1:0] exc_cause,
    input logic [XLEN-1:0]    exc_tval
);

    logic jr;
    logic rs_ret;
    logic rs_x7;

    assign jr     = (retire_insn[6:0] == 7'b1100111) && (retire_insn[14:12] == 3'b000);
    assign rs_ret = (retire_insn[19:15] == 5'd1) || (retire_insn[19:15] == 5'd5);
    assign rs_x7  = (retire_insn[19:15] == 5'd7);

    AST_TRACKED_ARMS: assert property (@(posedge clk) disable iff (rst)
        en && retire_vld && !armed && jr && !rs_ret && !rs_x7 |=> armed); // R2
    AST_RETURN_EXEMPT: assert property (@(posedge clk) disable iff (rst)
        en && retire_vld && !armed && jr && rs_ret |=> !armed); // R3
    AST_X7_EXEMPT: assert property (@(posedge clk) disable iff (rst)
        en && retire_vld && !armed && jr && rs_x7 |=> !armed); // R4
    AST_RESOLVE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        en && retire_vld && armed |=> !armed); // R8
    AST_HOLD_ARMED: assert property (@(posedge clk) disable iff (rst)
        en && !retire_vld && armed |=> armed); // R8
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |=> !exc_vld && !armed); // R9
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        exc_vld |=> !exc_vld); // R10
    AST_EXC_CODES: assert property (@(posedge clk) disable iff (rst)
        exc_vld |-> exc_cause == CAUSE_W'(CAUSE_SWCHK) && exc_tval == XLEN'(TVAL_LPAD)); // R10
    AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (rst)
        !exc_vld |-> exc_cause == '0 && exc_tval == '0); // R10
    AST_IDLE_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
        !armed |=> !exc_vld); // R11

endmodule

bind lpad_guard lpad_guard_sva #(
    .XLEN        (XLEN),
    .CAUSE_W     (CAUSE_W),
    .CAUSE_SWCHK (CAUSE_SWCHK),
    .TVAL_LPAD   (TVAL_LPAD)
) u_sva (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .retire_vld  (retire_vld),
    .retire_insn (retire_insn),
    .armed       (armed),
    .exc_vld     (exc_vld),
    .exc_cause   (exc_cause),
    .exc_tval    (exc_tval)
);

// File: tb/tb_lpad_guard.sv
module tb_lpad_guard;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN       = 64;
    localparam int CAUSE_W    = 8;
    localparam logic [31:0] NOP = 32'h0000_0013;

    logic               clk = 1'b0;
    logic               rst;
    logic               en;
    logic               retire_vld;
    logic [31:0]        retire_insn;
    logic [XLEN-1:0]    retire_pc;
    logic [XLEN-1:0]    x7_val;
    logic               exc_vld;
    logic [CAUSE_W-1:0] exc_cause;
    logic [XLEN-1:0]    exc_tval;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lpad_guard dut (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .retire_vld  (retire_vld),
        .retire_insn (retire_insn),
        .retire_pc   (retire_pc),
        .x7_val      (x7_val),
        .exc_vld     (exc_vld),
        .exc_cause   (exc_cause),
        .exc_tval    (exc_tval)
    );

    function automatic logic [31:0] jalr_of(input logic [4:0] rs1);
        return {12'h000, rs1, 3'b000, 5'd1, 7'b1100111};
    endfunction

    function automatic logic [31:0] pad_of(input logic [19:0] lbl);
        return {lbl, 5'd0, 7'b0010111};
    endfunction

    // drive one cycle at the falling edge, sample just after the rising edge
    task automatic step(input logic e, input logic v, input logic [31:0] insn,
                        input logic [XLEN-1:0] pc, input logic [XLEN-1:0] x7);
        @(negedge clk);
        en          = e;
        retire_vld  = v;
        retire_insn = insn;
        retire_pc   = pc;
        x7_val      = x7;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_exc(input string req, input logic want);
        n_checks++;
        if (want) begin
            if (!(exc_vld === 1'b1 && exc_cause === 8'd18 && exc_tval === 64'd2)) begin
                n_fail++;
                $display("FAIL %s: vld=%0b cause=%0d tval=%0d expected vld=1 cause=18 tval=2",
                         req, exc_vld, exc_cause, exc_tval);
            end
        end else begin
            if (!(exc_vld === 1'b0 && exc_cause === '0 && exc_tval === '0)) begin
                n_fail++;
                $display("FAIL %s: vld=%0b cause=%0d tval=%0d expected vld=0 cause=0 tval=0",
                         req, exc_vld, exc_cause, exc_tval);
            end
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        step(1'b1, 1'b0, NOP, 64'h1000, 64'h0);
        step(1'b1, 1'b0, NOP, 64'h1000, 64'h0);
        rst = 1'b0;
        expect_exc("R1 reset outputs", 1'b0);
        step(1'b1, 1'b1, NOP, 64'h1000, 64'h0);
        expect_exc("R1 idle after reset", 1'b0);
    endtask

    task automatic t_tracked;
        step(1'b1, 1'b1, jalr_of(5'd10), 64'h1000, 64'h0);
        expect_exc("R2 jump retires quietly", 1'b0);
        step(1'b1, 1'b1, NOP, 64'h2000, 64'h0);
        expect_exc("R2 missing pad", 1'b1);
        step(1'b1, 1'b0, NOP, 64'h2004, 64'h0);
        expect_exc("R10 pulse lasts one cycle", 1'b0);
        step(1'b1, 1'b1, jalr_of(5'd0), 64'h1000, 64'h0);
        step(1'b1, 1'b1, {20'h12345, 5'd5, 7'b0010111}, 64'h2000, 64'h0);
        expect_exc("R2 auipc to x5 is not a pad", 1'b1);
    endtask

    task automatic t_returns;
        step(1'b1, 1'b1, jalr_of(5'd1), 64'h1000, 64'h0);
        step(1'b1, 1'b1, NOP, 64'h2000, 64'h0);
        expect_exc("R3 x1 exempt", 1'b0);
        step(1'b1, 1'b1, jalr_of(5'd5), 64'h1000, 64'h0);
        step(1'b1, 1'b1, NOP, 64'h2000, 64'h0);
        expect_exc("R3 x5 exempt", 1'b0);
    endtask

    task automatic t_x7;
        step(1'b1, 1'b1, jalr_of(5'd7), 64'h1000, 64'h0);
        step(1'b1, 1'b1, NOP, 64'h2000, 64'h0);
        expect_exc("R4 x7 exempt", 1'b0);
    endtask

    task automatic t_zero_label;
        step(1'b1, 1'b1, jalr_of(5'd6), 64'h1000, 64'hDEAD_BEEF_1234_5678);
        step(1'b1, 1'b1, pad_of(20'h0), 64'h2000, 64'hDEAD_BEEF_1234_5678);
        expect_exc("R5 zero label skips compare", 1'b0);
    endtask

    task automatic t_labels;
        step(1'b1, 1'b1, jalr_of(5'd11), 64'h1000, 64'h0);
        step(1'b1, 1'b1, pad_of(20'hABCDE), 64'h2000, 64'h0000_0000_ABCD_E123);
        expect_exc("R6 label match", 1'b0);
        step(1'b1, 1'b1, jalr_of(5'd11), 64'h1000, 64'h0);
        step(1'b1, 1'b1, pad_of(20'hABCDE), 64'h2000, 64'hFFFF_FFFF_ABCD_EFFF);
        expect_exc("R6 other x7 bits ignored", 1'b0);
        step(1'b1, 1'b1, jalr_of(5'd11), 64'h1000, 64'h0);
        step(1'b1, 1'b1, pad_of(20'hABCDF), 64'h2000, 64'h0000_0000_ABCD_E000);
        expect_exc("R6 label mismatch", 1'b1);
    endtask

    task automatic t_misalign;
        step(1'b1, 1'b1, jalr_of(5'd12), 64'h1000, 64'h0);
        step(1'b1, 1'b1, pad_of(20'h0), 64'h2002, 64'h0);
        expect_exc("R7 pad off 4-byte boundary", 1'b1);
    endtask

    task automatic t_hold_clear;
        step(1'b1, 1'b1, jalr_of(5'd13), 64'h1000, 64'h0);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, NOP, 64'h0, 64'h0);
        step(1'b1, 1'b1, NOP, 64'h2000, 64'h0);
        expect_exc("R8 armed state held over gaps", 1'b1);
        step(1'b1, 1'b1, NOP, 64'h2004, 64'h0);
        expect_exc("R8 cleared after fault", 1'b0);
        step(1'b1, 1'b1, jalr_of(5'd13), 64'h1000, 64'h0);
        step(1'b1, 1'b1, pad_of(20'h0), 64'h2000, 64'h0);
        step(1'b1, 1'b1, NOP, 64'h2004, 64'h0);
        expect_exc("R8 cleared after pass", 1'b0);
    endtask

    task automatic t_disable;
        step(1'b0, 1'b1, jalr_of(5'd14), 64'h1000, 64'h0);
        step(1'b0, 1'b1, NOP, 64'h2000, 64'h0);
        expect_exc("R9 disabled never raises", 1'b0);
        step(1'b1, 1'b1, NOP, 64'h2004, 64'h0);
        expect_exc("R9 disabled jump did not arm", 1'b0);
        step(1'b1, 1'b1, jalr_of(5'd14), 64'h1000, 64'h0);
        step(1'b0, 1'b0, NOP, 64'h0, 64'h0);
        step(1'b1, 1'b1, NOP, 64'h2000, 64'h0);
        expect_exc("R9 disable drops armed state", 1'b0);
    endtask

    task automatic t_idle;
        step(1'b1, 1'b1, pad_of(20'h55555), 64'h3002, 64'h0);
        expect_exc("R11 bad pad while idle", 1'b0);
        step(1'b1, 1'b1, NOP, 64'h3006, 64'h0);
        expect_exc("R11 plain instruction while idle", 1'b0);
    endtask

    initial begin
        rst         = 1'b1;
        en          = 1'b0;
        retire_vld  = 1'b0;
        retire_insn = NOP;
        retire_pc   = '0;
        x7_val      = '0;
        t_reset();
        t_tracked();
        t_returns();
        t_x7();
        t_zero_label();
        t_labels();
        t_misalign();
        t_hold_clear();
        t_disable();
        t_idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule